// File: doc/BRIEF.md
# Flash Programming Host Controller

This block sits on the host side of an asynchronous 32-bit flash bus built from four independent byte-wide devices. Each device has its own chip select and owns one byte of the data bus. A single request names an operation, a target address, a write word and a mask of the byte lanes to act on. For that request the engine runs the multi-cycle unlock and command write sequence for a byte program, a sector erase or a whole-device erase. Every strobe edge is placed by clock-cycle counters, so the device minimums hold at whatever system clock the parameters are tuned for.

After the last command write, the engine reads the target address repeatedly with output enable low. It stops when bit 7 of every selected lane shows the expected value. If the per-operation timeout runs out first, it pulses the device reset, waits for the devices to recover and then reports an error. Lanes outside the mask never see their chip select asserted.

Top module: `flash_prog_ctrl`

## Requirements
- R1: `req_ready` is high exactly when the engine is idle. On the clock edge where `req_valid` and `req_ready` are both high, the request is taken. For a legal request, `req_ready` is low in the next cycle and stays low until the cycle in which `done` is high.
- R2: A byte program issues four write cycles as (address, byte placed on every lane): (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), then (request address, the request word itself).
- R3: A sector erase issues six write cycles: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55), then (request address, 0x30 on every lane).
- R4: A whole-device erase issues the same first five cycles as R3, then (0x5555, 0x10 on every lane).
- R5: Byte lane i is data bits [8i+7:8i] and is selected by `flash_cs_n[i]` (active low). A chip select is only ever driven low when its bit is set in the request lane mask, and every selected chip select is low during each write strobe and each status read.
- R6: In each write cycle, `flash_we_n` is low for exactly WP_CYC cycles. Address and write data stay stable and `flash_dq_oe` stays high while it is low. Between two strobes of one sequence, `flash_we_n` stays high for at least SETUP_CYC+WPH_CYC cycles.
- R7: Status reads drive `flash_oe_n` and the selected chip selects low for RD_CYC cycles, with `flash_dq_oe` low, and sample the bus in the last of them. The operation is complete on the first read in which, for every selected lane, data bit 7 equals the expected bit 7. That bit is bit 7 of that lane's write byte for a program, and 1 for either erase. Unselected lanes are ignored. Failed reads are separated by GAP_CYC cycles with output enable high.
- R8: Completion raises `done` for exactly one cycle, in the cycle after the successful sampling read, with `error` low.
- R9: If the poll time reaches TMO_PROG (program) or TMO_ERASE (erase) cycles first, `flash_rst_n` goes low for exactly RST_CYC cycles. Exactly RDY_CYC cycles after it returns high, `done` and `error` are high together.
- R10: A request with operation code 3 or an all-zero lane mask causes no bus cycle. It answers with `done` and `error` high in the cycle after acceptance.
- R11: `flash_we_n` is never low while `flash_oe_n` is low or `flash_rst_n` is low, and no chip select is low during the reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the engine |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted when valid is high |
| req_op | input | 2 | 0 program, 1 sector erase, 2 whole-device erase, 3 rejected |
| req_addr | input | AW | Program or sector address, also the polling address |
| req_data | input | 8*LANES | Word to program, one byte per lane |
| req_lanes | input | LANES | Lane mask, bit i enables lane i |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Qualifies done: rejected request or timeout |
| flash_addr | output | AW | Flash address bus |
| flash_dq_out | output | 8*LANES | Write data to the flash bus |
| flash_dq_oe | output | 1 | Host drives the data bus when high |
| flash_dq_in | input | 8*LANES | Read data from the flash bus |
| flash_we_n | output | 1 | Write strobe, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_cs_n | output | LANES | Per-lane chip selects, active low |
| flash_rst_n | output | 1 | Device reset, active low |

## Verification
The bus outputs come straight from the registered state. A request driven before an edge is taken at that edge, and `req_ready` falls, or a rejection answers with `done`, at the sample one cycle later. The bench drives and samples 2 ns after each falling edge, so every result is read exactly one register stage after its cause. The strobe monitor counts falling-edge samples: a strobe must show exactly WP_CYC low samples, and a reset pulse exactly RST_CYC. After a timeout, `done` must appear exactly RDY_CYC samples after the first sample with reset high again. For polling, the bench counts completed reads and expects exactly one more than the number of failing reads it scripted.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_RSVD = 2'd3
    } fpc_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_WLOW,
        S_WHIGH,
        S_PRD,
        S_PGAP,
        S_RSTLO,
        S_RSTWT
    } fpc_state_e;

    localparam logic [15:0] UNLOCK_A0 = 16'h5555;
    localparam logic [15:0] UNLOCK_A1 = 16'h2AAA;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] CMD_WRITE  = 8'hA0;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_SECTOR = 8'h30;
    localparam logic [7:0] CMD_WHOLE  = 8'h10;

endpackage

// File: rtl/fpc_cmd_seq.sv
module fpc_cmd_seq
    import fpc_pkg::*;
#(
    parameter int unsigned AW    = 21,
    parameter int unsigned LANES = 4
) (
    input  fpc_op_e              op,
    input  logic [2:0]           step,
    input  logic [AW-1:0]        tgt_addr,
    input  logic [8*LANES-1:0]   tgt_data,
    output logic [AW-1:0]        cyc_addr,
    output logic [8*LANES-1:0]   cyc_data,
    output logic                 cyc_last
);

    localparam logic [AW-1:0] A_HI = AW'(UNLOCK_A0);
    localparam logic [AW-1:0] A_LO = AW'(UNLOCK_A1);

    logic [7:0] byte_val;
    logic       use_word;

    always_comb begin
        cyc_addr = A_HI;
        byte_val = KEY_FIRST;
        use_word = 1'b0;
        cyc_last = 1'b0;
        if (op == OP_PROG) begin
            case (step)
                3'd0: begin cyc_addr = A_HI; byte_val = KEY_FIRST;  end
                3'd1: begin cyc_addr = A_LO; byte_val = KEY_SECOND; end
                3'd2: begin cyc_addr = A_HI; byte_val = CMD_WRITE;  end
                default: begin
                    cyc_addr = tgt_addr;
                    use_word = 1'b1;
                    cyc_last = 1'b1;
                end
            endcase
        end else begin
            case (step)
                3'd0: begin cyc_addr = A_HI; byte_val = KEY_FIRST;  end
                3'd1: begin cyc_addr = A_LO; byte_val = KEY_SECOND; end
                3'd2: begin cyc_addr = A_HI; byte_val = CMD_ERASE;  end
                3'd3: begin cyc_addr = A_HI; byte_val = KEY_FIRST;  end
                3'd4: begin cyc_addr = A_LO; byte_val = KEY_SECOND; end
                default: begin
                    cyc_last = 1'b1;
                    if (op == OP_SECT) begin
                        cyc_addr = tgt_addr;
                        byte_val = CMD_SECTOR;
                    end else begin
                        cyc_addr = A_HI;
                        byte_val = CMD_WHOLE;
                    end
                end
            endcase
        end
        cyc_data = use_word ? tgt_data : {LANES{byte_val}};
    end

endmodule

// File: rtl/fpc_lane_poll.sv
module fpc_lane_poll #(
    parameter int unsigned LANES = 4
) (
    input  logic [8*LANES-1:0] rd_data,
    input  logic [8*LANES-1:0] want,
    input  logic [LANES-1:0]   lane_en,
    output logic               all_ready
);

    logic [LANES-1:0] lane_ok;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ok[g] = !lane_en[g] || (rd_data[8*g+7] == want[8*g+7]);
    end

    assign all_ready = &lane_ok;

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import fpc_pkg::*;
#(
    parameter int unsigned AW        = 21,
    parameter int unsigned LANES     = 4,
    parameter int unsigned SETUP_CYC = 1,
    parameter int unsigned WP_CYC    = 3,
    parameter int unsigned WPH_CYC   = 2,
    parameter int unsigned RD_CYC    = 6,
    parameter int unsigned GAP_CYC   = 2,
    parameter int unsigned RST_CYC   = 25,
    parameter int unsigned RDY_CYC   = 1000,
    parameter int unsigned TMO_PROG  = 15000,
    parameter int unsigned TMO_ERASE = 750000000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_op,
    input  logic [AW-1:0]        req_addr,
    input  logic [8*LANES-1:0]   req_data,
    input  logic [LANES-1:0]     req_lanes,
    output logic                 done,
    output logic                 error,
    output logic [AW-1:0]        flash_addr,
    output logic [8*LANES-1:0]   flash_dq_out,
    output logic                 flash_dq_oe,
    input  logic [8*LANES-1:0]   flash_dq_in,
    output logic                 flash_we_n,
    output logic                 flash_oe_n,
    output logic [LANES-1:0]     flash_cs_n,
    output logic                 flash_rst_n
);

    localparam int unsigned DW      = 8 * LANES;
    localparam int unsigned PH_SUM  = SETUP_CYC + WP_CYC + WPH_CYC + RD_CYC
                                    + GAP_CYC + RST_CYC + RDY_CYC;
    localparam int unsigned CW      = $clog2(PH_SUM + 1);
    localparam int unsigned TMO_MAX = (TMO_ERASE > TMO_PROG) ? TMO_ERASE : TMO_PROG;
    localparam int unsigned TW      = $clog2(TMO_MAX + 1);

    typedef struct packed {
        fpc_state_e       st;
        logic [CW-1:0]    cnt;
        logic [TW-1:0]    tmo;
        logic [2:0]       step;
        fpc_op_e          op;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
        logic [LANES-1:0] lanes;
        logic             done;
        logic             err;
    } regs_t;

    regs_t q, d;

    logic [AW-1:0] seq_addr;
    logic [DW-1:0] seq_data;
    logic          seq_last;
    logic [DW-1:0] poll_want;
    logic          poll_ok;
    logic [TW-1:0] tmo_lim;

    fpc_cmd_seq #(.AW(AW), .LANES(LANES)) u_seq (
        .op       (q.op),
        .step     (q.step),
        .tgt_addr (q.addr),
        .tgt_data (q.data),
        .cyc_addr (seq_addr),
        .cyc_data (seq_data),
        .cyc_last (seq_last)
    );

    assign poll_want = (q.op == OP_PROG) ? q.data : '1;

    fpc_lane_poll #(.LANES(LANES)) u_poll (
        .rd_data   (flash_dq_in),
        .want      (poll_want),
        .lane_en   (q.lanes),
        .all_ready (poll_ok)
    );

    assign tmo_lim = (q.op == OP_PROG) ? TW'(TMO_PROG - 1) : TW'(TMO_ERASE - 1);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.op    = fpc_op_e'(req_op);
                    d.addr  = req_addr;
                    d.data  = req_data;
                    d.lanes = req_lanes;
                    d.step  = '0;
                    d.cnt   = '0;
                    d.tmo   = '0;
                    if (req_op == OP_RSVD || req_lanes == '0) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.st = S_SETUP;
                    end
                end
            end
            S_SETUP: begin
                if (q.cnt == CW'(SETUP_CYC - 1)) begin
                    d.st  = S_WLOW;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_WLOW: begin
                if (q.cnt == CW'(WP_CYC - 1)) begin
                    d.st  = S_WHIGH;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_WHIGH: begin
                if (q.cnt == CW'(WPH_CYC - 1)) begin
                    d.cnt = '0;
                    if (seq_last) begin
                        d.st  = S_PRD;
                        d.tmo = '0;
                    end else begin
                        d.st   = S_SETUP;
                        d.step = q.step + 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_PRD, S_PGAP: begin
                d.tmo = q.tmo + 1'b1;
                if (q.tmo == tmo_lim) begin
                    d.st  = S_RSTLO;
                    d.cnt = '0;
                end else if (q.st == S_PRD) begin
                    if (q.cnt == CW'(RD_CYC - 1)) begin
                        d.cnt = '0;
                        if (poll_ok) begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.st = S_PGAP;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end else begin
                    if (q.cnt == CW'(GAP_CYC - 1)) begin
                        d.st  = S_PRD;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            S_RSTLO: begin
                if (q.cnt == CW'(RST_CYC - 1)) begin
                    d.st  = S_RSTWT;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_RSTWT: begin
                if (q.cnt == CW'(RDY_CYC - 1)) begin
                    d.st   = S_IDLE;
                    d.cnt  = '0;
                    d.done = 1'b1;
                    d.err  = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.op    <= OP_PROG;
        end else begin
            q <= d;
        end
    end

    logic wr_phase;
    logic sel_phase;

    assign wr_phase  = (q.st == S_SETUP) || (q.st == S_WLOW) || (q.st == S_WHIGH);
    assign sel_phase = (q.st == S_SETUP) || (q.st == S_WLOW) || (q.st == S_PRD);

    assign req_ready    = (q.st == S_IDLE);
    assign done         = q.done;
    assign error        = q.err;
    assign flash_addr   = wr_phase ? seq_addr : q.addr;
    assign flash_dq_out = wr_phase ? seq_data : '0;
    assign flash_dq_oe  = wr_phase;
    assign flash_we_n   = (q.st != S_WLOW);
    assign flash_oe_n   = (q.st != S_PRD);
    assign flash_cs_n   = ~({LANES{sel_phase}} & q.lanes);
    assign flash_rst_n  = (q.st != S_RSTLO);

    // Checker state: length of the current write-strobe low run.
    logic [CW-1:0] we_low_run;
    always_ff @(posedge clk) begin
        if (!rst_n) we_low_run <= '0;
        else if (!flash_we_n) we_low_run <= we_low_run + 1'b1;
        else we_low_run <= '0;
    end

    // R6
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |-> (we_low_run == CW'(WP_CYC)));

    // R6
    we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_we_n && $past(!flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq_out)));

    // R11
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |-> (flash_oe_n && flash_dq_oe));

    // R11
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_rst_n |-> (flash_we_n && (&flash_cs_n)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready || done));

endmodule

// File: tb/tb_flash_prog_ctrl.sv
module tb_flash_prog_ctrl;

    localparam int AW = 21, SU = 1, WP = 3, WPH = 2, RD = 4, GAP = 2;
    localparam int RST = 5, RDY = 10, TP = 200, TE = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [3:0]  req_lanes = 4'h0;
    logic        done, error;
    logic [AW-1:0] f_addr;
    logic [31:0] f_dq_out, f_dq_in;
    logic        f_dq_oe, f_we_n, f_oe_n, f_rst_n;
    logic [3:0]  f_cs_n;

    always #10 clk = ~clk;

    flash_prog_ctrl #(
        .AW(AW), .LANES(4), .SETUP_CYC(SU), .WP_CYC(WP), .WPH_CYC(WPH),
        .RD_CYC(RD), .GAP_CYC(GAP), .RST_CYC(RST), .RDY_CYC(RDY),
        .TMO_PROG(TP), .TMO_ERASE(TE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_lanes(req_lanes),
        .done(done), .error(error), .flash_addr(f_addr), .flash_dq_out(f_dq_out),
        .flash_dq_oe(f_dq_oe), .flash_dq_in(f_dq_in), .flash_we_n(f_we_n),
        .flash_oe_n(f_oe_n), .flash_cs_n(f_cs_n), .flash_rst_n(f_rst_n)
    );

    int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0;

    // Responder: a selected lane shows the expected bit 7 only after `need` failing reads.
    logic [31:0] exp_word = '0;
    int need = 0, reads_base = 0, reads_seen = 0;
    logic [3:0] cur_mask = 4'h0;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            if (!f_cs_n[i] && (reads_seen - reads_base) >= need)
                f_dq_in[8*i +: 8] = exp_word[8*i +: 8];
            else
                f_dq_in[8*i +: 8] = {~exp_word[8*i+7], exp_word[8*i +: 7]};
        end
    end

    // Bus monitor, sampling on falling edges.
    logic [AW-1:0] log_addr [0:63];
    logic [31:0]   log_data [0:63];
    logic [3:0]    log_cs   [0:63];
    int log_n = 0, low_cnt = 0, high_cnt = 0, cyc = 0;
    int rst_low = 0, last_rst_w = 0, rst_pulses = 0, rst_rise_cyc = 0;
    logic prev_we = 1'b1, prev_oe = 1'b1, prev_rst = 1'b1;
    logic [AW-1:0] cap_addr;
    logic [31:0]   cap_dq;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if ((~f_cs_n & ~cur_mask) != 4'h0) begin
                mon_fails = mon_fails + 1;
                $display("FAIL R5 unselected chip select low: actual=%b mask=%b", f_cs_n, cur_mask);
            end
            if (!f_we_n) begin
                if (prev_we) begin
                    mon_checks = mon_checks + 1;
                    if (log_n > 0 && high_cnt < SU + WPH) begin
                        mon_fails = mon_fails + 1;
                        $display("FAIL R6 strobe high gap: actual=%0d expected>=%0d", high_cnt, SU + WPH);
                    end
                    cap_addr = f_addr;
                    cap_dq   = f_dq_out;
                    if (log_n < 64) begin
                        log_addr[log_n] = f_addr;
                        log_data[log_n] = f_dq_out;
                        log_cs[log_n]   = f_cs_n;
                    end
                    low_cnt = 1;
                end else begin
                    low_cnt = low_cnt + 1;
                end
                if (f_addr != cap_addr || f_dq_out != cap_dq || !f_oe_n || !f_dq_oe) begin
                    mon_fails = mon_fails + 1;
                    $display("FAIL R6 bus moved during strobe: actual=%h/%h expected=%h/%h",
                             f_addr, f_dq_out, cap_addr, cap_dq);
                end
            end else if (!prev_we) begin
                mon_checks = mon_checks + 1;
                if (low_cnt != WP) begin
                    mon_fails = mon_fails + 1;
                    $display("FAIL R6 strobe width: actual=%0d expected=%0d", low_cnt, WP);
                end
                log_n = log_n + 1;
                high_cnt = 1;
            end else begin
                high_cnt = high_cnt + 1;
            end
            if (!prev_oe && f_oe_n) reads_seen = reads_seen + 1;
            if (!f_rst_n) rst_low = rst_low + 1;
            else if (!prev_rst) begin
                last_rst_w   = rst_low;
                rst_low      = 0;
                rst_pulses   = rst_pulses + 1;
                rst_rise_cyc = cyc;
            end
        end
        prev_we  = f_we_n;
        prev_oe  = f_oe_n;
        prev_rst = f_rst_n;
    end

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_write(input int idx, input logic [AW-1:0] a, input logic [31:0] dv,
                             input logic [3:0] csn, input string req);
        chk(log_addr[idx] == a,   req, "write address", 64'(log_addr[idx]), 64'(a));
        chk(log_data[idx] == dv,  req, "write data",    64'(log_data[idx]), 64'(dv));
        chk(log_cs[idx]   == csn, req, "chip selects",  64'(log_cs[idx]),   64'(csn));
    endtask

    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [31:0] dv, input logic [3:0] m);
        req_op = op; req_addr = a; req_data = dv; req_lanes = m;
        req_valid = 1'b1;
        step();
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output int waited);
        waited = 0;
        while (!done && waited < 5000) begin
            step();
            waited++;
        end
        chk(done == 1'b1, "R8", "done seen", 64'(done), 64'd1);
    endtask

    task automatic finish_ok(input string req);
        chk(error == 1'b0, "R8", "error on success", 64'(error), 64'd0);
        step();
        chk(done == 1'b0, "R8", "done single cycle", 64'(done), 64'd0);
        chk(req_ready == 1'b1, "R1", "ready after done", 64'(req_ready), 64'd1);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
        chk({f_we_n, f_oe_n, f_rst_n, f_cs_n} == 7'h7F, "R11", "idle bus",
            64'({f_we_n, f_oe_n, f_rst_n, f_cs_n}), 64'h7F);
        chk(done == 1'b0, "R8", "no done after reset", 64'(done), 64'd0);
    endtask

    task automatic t_program();
        int base, w;
        base = log_n; cur_mask = 4'hF; exp_word = 32'h8A3C5511; need = 3;
        reads_base = reads_seen;
        issue(2'd0, 21'h01234, 32'h8A3C5511, 4'hF);
        chk(req_ready == 1'b0, "R1", "ready drops on accept", 64'(req_ready), 64'd0);
        wait_done(w);
        chk(log_n - base == 4, "R2", "program write count", 64'(log_n - base), 64'd4);
        chk_write(base + 0, 21'h05555, 32'hAAAAAAAA, 4'h0, "R2");
        chk_write(base + 1, 21'h02AAA, 32'h55555555, 4'h0, "R2");
        chk_write(base + 2, 21'h05555, 32'hA0A0A0A0, 4'h0, "R2");
        chk_write(base + 3, 21'h01234, 32'h8A3C5511, 4'h0, "R2");
        chk(reads_seen - reads_base == need + 1, "R7", "program poll reads",
            64'(reads_seen - reads_base), 64'(need + 1));
        finish_ok("R2");
    endtask

    task automatic t_sector();
        int base, w;
        base = log_n; cur_mask = 4'h5; exp_word = 32'hFFFFFFFF; need = 0;
        reads_base = reads_seen;
        issue(2'd1, 21'h1F0000, 32'h0, 4'h5);
        wait_done(w);
        chk(log_n - base == 6, "R3", "sector write count", 64'(log_n - base), 64'd6);
        chk_write(base + 0, 21'h05555, 32'hAAAAAAAA, 4'hA, "R5");
        chk_write(base + 2, 21'h05555, 32'h80808080, 4'hA, "R3");
        chk_write(base + 4, 21'h02AAA, 32'h55555555, 4'hA, "R3");
        chk_write(base + 5, 21'h1F0000, 32'h30303030, 4'hA, "R3");
        chk(reads_seen - reads_base == 1, "R7", "unselected lanes ignored, one read",
            64'(reads_seen - reads_base), 64'd1);
        finish_ok("R3");
    endtask

    task automatic t_chip();
        int base, w;
        base = log_n; cur_mask = 4'hF; exp_word = 32'hFFFFFFFF; need = 2;
        reads_base = reads_seen;
        issue(2'd2, 21'h00777, 32'h0, 4'hF);
        wait_done(w);
        chk(log_n - base == 6, "R4", "chip erase write count", 64'(log_n - base), 64'd6);
        chk_write(base + 3, 21'h05555, 32'hAAAAAAAA, 4'h0, "R4");
        chk_write(base + 5, 21'h05555, 32'h10101010, 4'h0, "R4");
        chk(reads_seen - reads_base == need + 1, "R7", "chip erase poll reads",
            64'(reads_seen - reads_base), 64'(need + 1));
        finish_ok("R4");
    endtask

    task automatic t_timeout();
        int w, pulses0;
        pulses0 = rst_pulses; cur_mask = 4'h2; exp_word = 32'h00800000; need = 1000000;
        reads_base = reads_seen;
        issue(2'd0, 21'h00010, 32'h00800000, 4'h2);
        wait_done(w);
        chk(error == 1'b1, "R9", "error on timeout", 64'(error), 64'd1);
        chk(rst_pulses == pulses0 + 1, "R9", "one reset pulse", 64'(rst_pulses), 64'(pulses0 + 1));
        chk(last_rst_w == RST, "R9", "reset pulse width", 64'(last_rst_w), 64'(RST));
        chk(cyc - rst_rise_cyc == RDY, "R9", "recovery wait", 64'(cyc - rst_rise_cyc), 64'(RDY));
        step();
        chk(done == 1'b0, "R8", "timeout done single cycle", 64'(done), 64'd0);
    endtask

    task automatic t_reject();
        int base;
        base = log_n; cur_mask = 4'h0;
        issue(2'd3, 21'h0, 32'h0, 4'hF);
        chk(done && error, "R10", "reserved op rejected", 64'({done, error}), 64'h3);
        step();
        issue(2'd0, 21'h0, 32'h12345678, 4'h0);
        chk(done && error, "R10", "empty mask rejected", 64'({done, error}), 64'h3);
        step();
        chk(log_n == base, "R10", "no bus cycles", 64'(log_n), 64'(base));
        chk(req_ready == 1'b1, "R1", "ready after reject", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, fails + mon_fails + 1);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_program();
        t_sector();
        t_chip();
        t_timeout();
        t_reject();
        repeat (3) step();
        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
        $finish;
    end

endmodule